// File: doc/BRIEF.md
# Beat-wise predicate mask setter

This block keeps the predication mask register of a four-beat vector pipeline up to date when a "predicate-then" command arrives. An instruction can be interrupted between beats and resumed later. The caller therefore hands in a 3-bit continuation code with each command. The code says which beats already ran before the resume. The block checks that code first and then decides which of two adjacent 4-bit mask fields the command may write. The lower field covers beats 0 and 1, and the upper field covers beats 2 and 3.

The mask fields change only on odd-numbered beats. If beat 1 already ran, the lower field was written during the first attempt and must not be written again. Once a command is accepted, the block produces the continuation code that applies to the following instruction, and it also presents that code in a packed status byte. A command with a zero mask is rejected as undefined. A command that carries a reserved code raises a fault. A rejected command changes no state. All outputs are registered and show the effect of a command one cycle after its strobe.

Top module: `beat_pred_mask`

## Requirements
- R1: After reset, `pred_o`, `cont_code_o` and `status_o` are zero, and `fault_o` and `undef_o` are low.
- R2: The continuation codes 0 (nothing done), 1 (beat 0 done), 2 (beats 0-1 done), 3 (beats 0-2 done) and 4 (beats 0-2 and the next instruction's beat 0 done) are legal. A command with a nonzero mask and a code of 5, 6 or 7 pulses `fault_o` for one cycle and leaves `pred_o` and `cont_code_o` unchanged.
- R3: A command with mask 0 pulses `undef_o` for one cycle, keeps `fault_o` low whatever its code, and leaves `pred_o` and `cont_code_o` unchanged.
- R4: An accepted command with code 0 or 1 writes the mask into both the lower field `pred_o[19:16]` and the upper field `pred_o[23:20]`.
- R5: An accepted command with code 2, 3 or 4 writes the mask into `pred_o[23:20]` only. `pred_o[19:16]` keeps its previous value.
- R6: Bits of `pred_o` outside [23:16] never change, so they stay zero from reset onward.
- R7: After an accepted command, `cont_code_o` becomes 1 if the command's code was 4, and 0 for any other legal code.
- R8: `status_o` always equals `{1'b0, cont_code_o, 4'b0000}`, which is the continuation code shifted left by four.
- R9: The outputs reflect a command in the cycle after its strobe. In a cycle with no strobe, `pred_o` and `cont_code_o` hold, and both flags are low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Predicate-then command strobe |
| cmd_mask_i | input | 4 | Mask operand of the command |
| cont_code_i | input | 3 | Continuation code that applies to this command |
| pred_o | output | 32 | Predication register, mask fields in [23:16] |
| cont_code_o | output | 3 | Continuation code after the last accepted command |
| status_o | output | 8 | Packed status byte carrying the code in [6:4] |
| fault_o | output | 1 | One-cycle pulse: reserved continuation code |
| undef_o | output | 1 | One-cycle pulse: zero mask rejected |

## Verification
Suppose the block picks the wrong field-write decision for a continuation code. The lower mask field then shows a stale or overwritten nibble on `pred_o[19:16]` in the very next cycle. The bench catches this by first loading a known nibble into both fields and then issuing the command under test. A wrong code-advance rule shows up at once on `cont_code_o` and `status_o`. A broken reject path shows up either as a mask change or as a missing or doubled flag pulse, one cycle after the strobe.

// File: rtl/bpm_pkg.sv
`timescale 1ns/1ps
package bpm_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CONT_IDLE  = 3'd0,
    CONT_B0    = 3'd1,
    CONT_B01   = 3'd2,
    CONT_B012  = 3'd3,
    CONT_B012N = 3'd4
  } cont_e;
endpackage

// File: rtl/bpm_code_step.sv
`timescale 1ns/1ps
// Classifies a continuation code: legality, whether beat 1 already ran,
// and the code that follows once the instruction completes.
module bpm_code_step
  import bpm_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              legal_o,
  output logic              beat1_done_o,
  output logic [CODE_W-1:0] next_o
);
  always_comb begin
    legal_o      = 1'b1;
    beat1_done_o = 1'b0;
    next_o       = CONT_IDLE;
    unique case (code_i)
      CONT_IDLE:  next_o = CONT_IDLE;
      CONT_B0:    next_o = CONT_IDLE;
      CONT_B01,
      CONT_B012:  beat1_done_o = 1'b1;
      CONT_B012N: begin
        beat1_done_o = 1'b1;
        next_o       = CONT_B0;
      end
      default: begin
        legal_o = 1'b0;
        next_o  = code_i;
      end
    endcase
  end
endmodule

// File: rtl/bpm_field_merge.sv
`timescale 1ns/1ps
// Deposits the mask into the predicate fields. The lower half of the fields
// is skipped when the beats that own it already completed.
module bpm_field_merge #(
  parameter int REG_W      = 32,
  parameter int FIELD_W    = 4,
  parameter int FIELD_LSB  = 16,
  parameter int NUM_FIELDS = 2
) (
  input  logic [REG_W-1:0]   cur_i,
  input  logic [FIELD_W-1:0] mask_i,
  input  logic               upper_only_i,
  output logic [REG_W-1:0]   nxt_o
);
  localparam int FIELD_TOP = FIELD_LSB + NUM_FIELDS * FIELD_W;

  assign nxt_o[FIELD_LSB-1:0]     = cur_i[FIELD_LSB-1:0];
  assign nxt_o[REG_W-1:FIELD_TOP] = cur_i[REG_W-1:FIELD_TOP];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam bit IS_UPPER = (g >= NUM_FIELDS / 2);
    logic wr;
    assign wr = IS_UPPER || !upper_only_i;
    assign nxt_o[FIELD_LSB + g*FIELD_W +: FIELD_W] =
      wr ? mask_i : cur_i[FIELD_LSB + g*FIELD_W +: FIELD_W];
  end
endmodule

// File: rtl/beat_pred_mask.sv
`timescale 1ns/1ps
module beat_pred_mask
  import bpm_pkg::*;
#(
  parameter int REG_W        = 32,
  parameter int FIELD_W      = 4,
  parameter int FIELD_LSB    = 16,
  parameter int STATUS_W     = 8,
  parameter int STATUS_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid_i,
  input  logic [FIELD_W-1:0]  cmd_mask_i,
  input  logic [CODE_W-1:0]   cont_code_i,
  output logic [REG_W-1:0]    pred_o,
  output logic [CODE_W-1:0]   cont_code_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                fault_o,
  output logic                undef_o
);
  localparam int STATUS_PAD = STATUS_W - CODE_W - STATUS_SHIFT;

  logic [REG_W-1:0]  pred_q, pred_d, merged;
  logic [CODE_W-1:0] code_q, code_d, code_next;
  logic              fault_q, fault_d, undef_q, undef_d;
  logic              legal, beat1_done, mask_zero, accept, upd_en;

  bpm_code_step u_step (
    .code_i       (cont_code_i),
    .legal_o      (legal),
    .beat1_done_o (beat1_done),
    .next_o       (code_next)
  );

  bpm_field_merge #(
    .REG_W      (REG_W),
    .FIELD_W    (FIELD_W),
    .FIELD_LSB  (FIELD_LSB),
    .NUM_FIELDS (2)
  ) u_merge (
    .cur_i        (pred_q),
    .mask_i       (cmd_mask_i),
    .upper_only_i (beat1_done),
    .nxt_o        (merged)
  );

  assign mask_zero = (cmd_mask_i == '0);
  assign accept    = legal && !mask_zero;
  assign upd_en    = cmd_valid_i && accept;

  // Next-state process
  always_comb begin
    pred_d  = pred_q;
    code_d  = code_q;
    fault_d = 1'b0;
    undef_d = 1'b0;
    if (cmd_valid_i) begin
      if (mask_zero) begin
        undef_d = 1'b1;
      end else if (!legal) begin
        fault_d = 1'b1;
      end else begin
        pred_d = merged;
        code_d = code_next;
      end
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q  <= '0;
      code_q  <= CONT_IDLE;
      fault_q <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      if (upd_en) begin
        pred_q <= pred_d;
        code_q <= code_d;
      end
      fault_q <= fault_d;
      undef_q <= undef_d;
    end
  end

  assign pred_o      = pred_q;
  assign cont_code_o = code_q;
  assign status_o    = {{STATUS_PAD{1'b0}}, code_q, {STATUS_SHIFT{1'b0}}};
  assign fault_o     = fault_q;
  assign undef_o     = undef_q;
endmodule

// File: rtl/bpm_checker.sv
`timescale 1ns/1ps
module bpm_checker #(
  parameter int REG_W     = 32,
  parameter int FIELD_W   = 4,
  parameter int FIELD_LSB = 16,
  parameter int STATUS_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid_i,
  input logic [FIELD_W-1:0]  cmd_mask_i,
  input logic [2:0]          cont_code_i,
  input logic [REG_W-1:0]    pred_o,
  input logic [2:0]          cont_code_o,
  input logic [STATUS_W-1:0] status_o,
  input logic                fault_o,
  input logic                undef_o
);
  localparam int HI_LSB = FIELD_LSB + FIELD_W;
  localparam int TOP    = FIELD_LSB + 2 * FIELD_W;

  logic ok_cmd;
  assign ok_cmd = cmd_valid_i && (cmd_mask_i != '0) && (cont_code_i <= 3'd4);

  assert_undef_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && cmd_mask_i == '0 |=> undef_o && !fault_o && $stable(pred_o) && $stable(cont_code_o));

  assert_reserved_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && cmd_mask_i != '0 && cont_code_i > 3'd4 |=> fault_o && $stable(pred_o) && $stable(cont_code_o));

  assert_both_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ok_cmd && cont_code_i <= 3'd1 |=>
      pred_o[FIELD_LSB +: FIELD_W] == $past(cmd_mask_i) && pred_o[HI_LSB +: FIELD_W] == $past(cmd_mask_i));

  assert_upper_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ok_cmd && cont_code_i >= 3'd2 |=>
      $stable(pred_o[FIELD_LSB +: FIELD_W]) && pred_o[HI_LSB +: FIELD_W] == $past(cmd_mask_i));

  assert_other_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(pred_o[FIELD_LSB-1:0]) && $stable(pred_o[REG_W-1:TOP]));

  assert_code_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ok_cmd |=> cont_code_o == (($past(cont_code_i) == 3'd4) ? 3'd1 : 3'd0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_i |=> $stable(pred_o) && $stable(cont_code_o) && !fault_o && !undef_o);

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_o, undef_o}));

  always_comb begin
    if (rst_n) begin
      assert_status_pack_R8: assert (status_o[STATUS_W-1:0] == {1'b0, cont_code_o, 4'b0000});
    end
  end
endmodule

bind beat_pred_mask bpm_checker #(
  .REG_W     (REG_W),
  .FIELD_W   (FIELD_W),
  .FIELD_LSB (FIELD_LSB),
  .STATUS_W  (STATUS_W)
) u_bpm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid_i (cmd_valid_i),
  .cmd_mask_i  (cmd_mask_i),
  .cont_code_i (cont_code_i),
  .pred_o      (pred_o),
  .cont_code_o (cont_code_o),
  .status_o    (status_o),
  .fault_o     (fault_o),
  .undef_o     (undef_o)
);

// File: tb/tb_beat_pred_mask.sv
`timescale 1ns/1ps
module tb_beat_pred_mask;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [3:0]  cmd_mask_i = 4'd0;
  logic [2:0]  cont_code_i = 3'd0;
  logic [31:0] pred_o;
  logic [2:0]  cont_code_o;
  logic [7:0]  status_o;
  logic        fault_o, undef_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_pred = 32'd0;
  logic [2:0]  m_code = 3'd0;

  always #4 clk = ~clk;

  beat_pred_mask dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_mask_i(cmd_mask_i),
    .cont_code_i(cont_code_i), .pred_o(pred_o), .cont_code_o(cont_code_o),
    .status_o(status_o), .fault_o(fault_o), .undef_o(undef_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input logic exp_fault, input logic exp_undef);
    chk("R4/R5/R6 pred", pred_o, m_pred);
    chk("R7 code", {29'd0, cont_code_o}, {29'd0, m_code});
    chk("R8 status", {24'd0, status_o}, {24'd0, 1'b0, m_code, 4'b0000});
    chk("R2 fault", {31'd0, fault_o}, {31'd0, exp_fault});
    chk("R3 undef", {31'd0, undef_o}, {31'd0, exp_undef});
  endtask

  // Issue one command; check results one cycle later (R9)
  task automatic do_cmd(input logic [2:0] c, input logic [3:0] m);
    logic ef, eu;
    ef = 1'b0; eu = 1'b0;
    cmd_valid_i = 1'b1; cont_code_i = c; cmd_mask_i = m;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    if (m == 4'd0) eu = 1'b1;
    else if (c > 3'd4) ef = 1'b1;
    else begin
      m_pred[23:20] = m;
      if (c <= 3'd1) m_pred[19:16] = m;
      m_code = (c == 3'd4) ? 3'd1 : 3'd0;
    end
    check_all(ef, eu);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_all(1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all(1'b0, 1'b0);
    for (int p = 1; p < 16; p++) begin
      for (int c = 0; c < 8; c++) begin
        for (int m = 0; m < 16; m++) begin
          do_cmd(3'd0, 4'(p));        // R4 preload of both fields
          if (p[0]) do_cmd(3'd4, 4'(p)); // leaves code 1 before the next command (R7)
          do_cmd(3'(c), 4'(m));      // R2 R3 R4 R5 R7 under test
          @(negedge clk);            // R9 idle cycle: hold, flags low
          check_all(1'b0, 1'b0);
        end
      end
    end
    // R1: reset again in mid-run
    rst_n = 1'b0;
    m_pred = 32'd0; m_code = 3'd0;
    @(negedge clk);
    check_all(1'b0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule